// File: doc/BRIEF.md
# Two-Wire Byte Handshake Controller

This block is the byte engine of a two-wire serial controller with open-drain clock and data lines. It moves one byte plus its acknowledge slot per transfer. As a transmitter it puts a byte from the host onto the data line and records the acknowledge the receiver returns. As a receiver it gathers a byte and answers with an acknowledge or a not-acknowledge. START generation, arbitration, address matching and bit-rate generation are left to neighbouring logic. This block only watches the clock line. The one exception is in slave mode, where it holds the clock line low.

The host sees a single status flag, `pin`, which is active low. Hardware pulls it low when a byte finishes, when a bus error occurs, or when a STOP arrives while acting as slave receiver. The host returns it high through the data port. In transmit mode the data port is a valid/ready write stream (`s_*`). `s_ready` is high only while no byte is on the wire, and a held `s_valid` simply waits. In receive mode it is a valid/ready read stream (`m_*`). `m_valid` is high while `pin` is low, and the handshake counts as the register read. The role comes from `cfg_master` and `cfg_tx`.

Top module: `twb_byte_ctrl`

## Requirements
- R1: With `cfg_ack_en`=1 in receive mode (`cfg_tx`=0), the block pulls SDA low through the whole ninth clock of every byte.
- R2: With `cfg_ack_en`=0 in receive mode, SDA stays released on the ninth clock (not-acknowledge).
- R3: Data bits move most significant bit first. Received bits are taken on the rising SCL edge and appear on `m_data` once the byte completes. A transmitted byte is driven bit by bit onto SDA. The level seen on the ninth clock is reported on `sts_ack_rx` (1 = not acknowledged).
- R4: `pin` drops to 0 within four system clocks after the falling SCL edge that ends the ninth clock.
- R5: In transmit mode an accepted `s_valid`/`s_ready` handshake sets `pin` to 1. `s_ready` is 1 only when `cfg_tx`=1 and no bit of a byte has been clocked yet.
- R6: In receive mode an accepted `m_valid`/`m_ready` handshake sets `pin` to 1. `m_valid` is 1 exactly when `cfg_tx`=0 and `pin`=0.
- R7: `int_n` is 0 whenever `cfg_int_en`=1 and `pin`=0, and it is 1 otherwise.
- R8: In slave mode (`cfg_master`=0), SCL is held low after a byte completes, for as long as `pin` stays 0. In master mode the block never drives SCL.
- R9: In slave-receive mode (`cfg_master`=0, `cfg_tx`=0), a STOP outside a byte sets `pin` to 0 and `sts_stop` to 1, and does not stretch SCL. In other modes a STOP leaves `pin` unchanged.
- R10: A START or STOP after the first and before the end of the ninth clock is a bus error. It sets `pin` to 0 and `sts_ber` to 1, releases SCL and SDA, and abandons the partial byte.
- R11: When `pin` returns to 1, `sts_ber` and `sts_stop` are cleared.
- R12: After reset `pin`=1, `int_n`=1, `scl_oe`=0, `sda_oe`=0, `sts_ber`=0 and `sts_stop`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Clock line level |
| sda_i | input | 1 | Data line level |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_tx | input | 1 | 1 = transmitter, 0 = receiver |
| cfg_ack_en | input | 1 | Acknowledge received bytes |
| cfg_int_en | input | 1 | Enable interrupt output |
| s_valid | input | 1 | Transmit byte offered |
| s_ready | output | 1 | Transmit byte can be taken |
| s_data | input | 8 | Transmit byte |
| m_valid | output | 1 | Received byte available |
| m_ready | input | 1 | Host takes received byte |
| m_data | output | 8 | Last received byte |
| pin | output | 1 | Pending flag, 0 = service needed |
| int_n | output | 1 | Interrupt, active low |
| sts_ber | output | 1 | Bus error seen |
| sts_stop | output | 1 | STOP seen as slave receiver |
| sts_ack_rx | output | 1 | Level sampled on ninth clock |

## Verification
A bit-slot counter that is off by one shows on the wire before anything else. The acknowledge drive lands on a data bit, or `pin` falls one SCL period early or late. The bench catches this on the first byte through the R1 and R4 checks. If the shift register is wrong, the very next byte shows a wrong `m_data` or a wrong serialised pattern. The sweep over every byte value exposes a stuck or swapped bit within 256 transfers. Wrong `pin` or status sequencing shows a few system clocks after the triggering edge, as stretching that never ends or never starts, or as status that stays set after a service handshake.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
    logic start;
    logic stop;
  } twb_evt_t;

  // encoding follows {cfg_master, cfg_tx}
  typedef enum logic [1:0] {
    ROLE_SLV_RX = 2'b00,
    ROLE_SLV_TX = 2'b01,
    ROLE_MST_RX = 2'b10,
    ROLE_MST_TX = 2'b11
  } twb_role_e;
endpackage

// File: rtl/twb_line_sync.sv
module twb_line_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    logic nxt;
    logic ff;
    if (i == 0) begin : g_first
      assign nxt = d;
    end else begin : g_rest
      assign nxt = chain[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= RST_VAL;
      else        ff <= nxt;
    end
    assign chain[i] = ff;
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/twb_cond_det.sv
module twb_cond_det
  import twb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_s,
  input  logic     sda_s,
  output twb_evt_t evt
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    evt.rise  = scl_s & ~scl_q;
    evt.fall  = ~scl_s & scl_q;
    evt.start = scl_s & scl_q & sda_q & ~sda_s;
    evt.stop  = scl_s & scl_q & ~sda_q & sda_s;
  end
endmodule

// File: rtl/twb_bit_engine.sv
module twb_bit_engine
  import twb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  twb_evt_t          evt,
  input  logic              sda_s,
  input  logic              tx_mode,
  input  logic              ack_en,
  input  logic              mute,
  input  logic              drop,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              in_byte,
  output logic              idle,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte,
  output logic              ack_bit,
  output logic              sda_oe
);
  localparam int SLOT_W = $clog2(DATA_W + 1);
  localparam logic [SLOT_W-1:0] ACK_SLOT = SLOT_W'(DATA_W);

  logic [SLOT_W-1:0] slot;
  logic              hi_seen;
  logic              tx_loaded;
  logic [DATA_W-1:0] txsh, rxsh, rx_q;
  logic              ack_q;
  logic              cond;

  assign cond = evt.start | evt.stop;
  assign done = evt.fall & hi_seen & (slot == ACK_SLOT) & ~cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot    <= '0;
      hi_seen <= 1'b0;
      rxsh    <= '0;
      rx_q    <= '0;
      ack_q   <= 1'b1;
    end else if (cond) begin
      slot    <= '0;
      hi_seen <= 1'b0;
    end else begin
      if (evt.rise) begin
        hi_seen <= 1'b1;
        if (slot != ACK_SLOT) rxsh <= {rxsh[DATA_W-2:0], sda_s};
        else                  ack_q <= sda_s;
      end
      if (evt.fall && hi_seen) begin
        hi_seen <= 1'b0;
        if (slot == ACK_SLOT) begin
          slot <= '0;
          rx_q <= rxsh;
        end else begin
          slot <= slot + SLOT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_loaded <= 1'b0;
      txsh      <= '1;
    end else if (drop) begin
      tx_loaded <= 1'b0;
    end else if (load) begin
      tx_loaded <= 1'b1;
      txsh      <= load_data;
    end else if (done) begin
      tx_loaded <= 1'b0;
    end else if (evt.fall && hi_seen && !cond && slot != ACK_SLOT) begin
      txsh <= txsh << 1;
    end
  end

  always_comb begin
    if (mute)         sda_oe = 1'b0;
    else if (tx_mode) sda_oe = tx_loaded & (slot != ACK_SLOT) & ~txsh[DATA_W-1];
    else              sda_oe = ack_en & (slot == ACK_SLOT);
  end

  assign in_byte = (slot != '0);
  assign idle    = (slot == '0) & ~hi_seen;
  assign rx_byte = rx_q;
  assign ack_bit = ack_q;
endmodule

// File: rtl/twb_byte_ctrl.sv
module twb_byte_ctrl
  import twb_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              cfg_master,
  input  logic              cfg_tx,
  input  logic              cfg_ack_en,
  input  logic              cfg_int_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              pin,
  output logic              int_n,
  output logic              sts_ber,
  output logic              sts_stop,
  output logic              sts_ack_rx
);
  twb_role_e role;
  twb_evt_t  evt;
  logic      scl_s, sda_s;
  logic      in_byte, idle, done;
  logic      ber_ev, stop_ev, clr_ev, set_ev, s_fire, m_fire;
  logic      pin_q, ber_q, stop_q;

  assign role = twb_role_e'({cfg_master, cfg_tx});

  twb_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) scl_sync_i (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  twb_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sda_sync_i (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  twb_cond_det cond_i (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .evt(evt));

  twb_bit_engine #(.DATA_W(DATA_W)) eng_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt),
    .sda_s    (sda_s),
    .tx_mode  (cfg_tx),
    .ack_en   (cfg_ack_en),
    .mute     (ber_q),
    .drop     (ber_ev),
    .load     (s_fire),
    .load_data(s_data),
    .in_byte  (in_byte),
    .idle     (idle),
    .done     (done),
    .rx_byte  (m_data),
    .ack_bit  (sts_ack_rx),
    .sda_oe   (sda_oe)
  );

  assign s_ready = cfg_tx & idle;
  assign m_valid = ~cfg_tx & ~pin_q;
  assign s_fire  = s_valid & s_ready;
  assign m_fire  = m_valid & m_ready;

  assign ber_ev  = (evt.start | evt.stop) & in_byte;
  assign stop_ev = evt.stop & ~in_byte & (role == ROLE_SLV_RX);
  assign clr_ev  = done | ber_ev | stop_ev;
  assign set_ev  = s_fire | m_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= 1'b1;
      ber_q  <= 1'b0;
      stop_q <= 1'b0;
    end else if (clr_ev) begin
      pin_q <= 1'b0;
      if (ber_ev)  ber_q  <= 1'b1;
      if (stop_ev) stop_q <= 1'b1;
    end else if (set_ev) begin
      pin_q  <= 1'b1;
      ber_q  <= 1'b0;
      stop_q <= 1'b0;
    end
  end

  assign scl_oe   = ~cfg_master & ~pin_q & ~ber_q & ~stop_q;
  assign int_n    = ~(cfg_int_en & ~pin_q);
  assign pin      = pin_q;
  assign sts_ber  = ber_q;
  assign sts_stop = stop_q;
endmodule

// File: rtl/twb_byte_ctrl_chk.sv
module twb_byte_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic pin,
  input logic int_n,
  input logic cfg_int_en,
  input logic cfg_master,
  input logic s_valid,
  input logic s_ready,
  input logic m_valid,
  input logic m_ready,
  input logic sts_ber,
  input logic sts_stop,
  input logic scl_oe,
  input logic sda_oe
);
  AST_PIN_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin) |-> ($past(s_valid && s_ready) || $past(m_valid && m_ready))); // R5
  AST_STATUS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin) |-> (!sts_ber && !sts_stop)); // R11
  AST_INT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(pin) && cfg_int_en) |-> !int_n); // R7
  AST_INT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    pin |-> int_n); // R7
  AST_BER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    sts_ber |-> (!scl_oe && !sda_oe)); // R10
  AST_STRETCH_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_oe) && !cfg_master) |-> (pin || sts_ber || sts_stop)); // R8
endmodule

bind twb_byte_ctrl twb_byte_ctrl_chk chk_i (.*);

// File: tb/twb_byte_ctrl_tb_top.sv
`timescale 1ns/1ps
module twb_byte_ctrl_tb_top;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic tb_scl_low = 1'b0, tb_sda_low = 1'b0;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic cfg_master = 1'b0, cfg_tx = 1'b0, cfg_ack_en = 1'b1, cfg_int_en = 1'b1;
  logic s_valid = 1'b0, s_ready, m_valid, m_ready = 1'b0;
  logic [7:0] s_data = 8'h00, m_data;
  logic pin, int_n, sts_ber, sts_stop, sts_ack_rx;

  assign scl_line = ~(scl_oe | tb_scl_low);
  assign sda_line = ~(sda_oe | tb_sda_low);

  twb_byte_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .cfg_master(cfg_master), .cfg_tx(cfg_tx), .cfg_ack_en(cfg_ack_en), .cfg_int_en(cfg_int_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .pin(pin), .int_n(int_n), .sts_ber(sts_ber), .sts_stop(sts_stop), .sts_ack_rx(sts_ack_rx));

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (scl_line !== 1'b1) @(negedge clk);
  endtask

  task automatic clk_bit(input logic drv, output logic smp);
    tb_sda_low = ~drv;
    wclk(HALF);
    tb_scl_low = 1'b0;
    wait_scl_high();
    wclk(HALF);
    smp = sda_line;
    tb_scl_low = 1'b1;
    wclk(HALF);
  endtask

  task automatic bus_start();
    tb_sda_low = 1'b0;
    wclk(HALF);
    tb_scl_low = 1'b0;
    wait_scl_high();
    wclk(HALF);
    tb_sda_low = 1'b1;
    wclk(HALF);
    tb_scl_low = 1'b1;
    wclk(HALF);
  endtask

  task automatic bus_stop();
    tb_sda_low = 1'b1;
    wclk(HALF);
    tb_scl_low = 1'b0;
    wait_scl_high();
    wclk(HALF);
    tb_sda_low = 1'b0;
    wclk(8);
  endtask

  task automatic host_read();
    @(negedge clk) m_ready = 1'b1;
    @(negedge clk) m_ready = 1'b0;
    wclk(2);
  endtask

  task automatic host_write(input logic [7:0] v);
    @(negedge clk) begin s_valid = 1'b1; s_data = v; end
    @(negedge clk) s_valid = 1'b0;
    wclk(2);
  endtask

  // master sends byte to the block, returns level seen on ninth clock
  task automatic send_byte(input logic [7:0] v, output logic ack_lvl);
    logic d;
    for (int j = 7; j >= 0; j--) clk_bit(v[j], d);
    clk_bit(1'b1, ack_lvl);
    tb_sda_low = 1'b0;
    wclk(8);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x1 expected 0x0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] got;
    wclk(3);
    rst_n = 1'b1;
    wclk(3);
    // R12 reset state
    chk("R12 pin", pin, 1); chk("R12 int_n", int_n, 1);
    chk("R12 scl_oe", scl_oe, 0); chk("R12 sda_oe", sda_oe, 0);
    chk("R12 ber", sts_ber, 0); chk("R12 stop", sts_stop, 0);

    // slave receiver, all byte values
    cfg_master = 0; cfg_tx = 0; cfg_ack_en = 1; cfg_int_en = 1;
    chk("R5 s_ready low in rx", s_ready, 0);
    bus_start();
    for (int v = 0; v < 256; v++) begin
      send_byte(8'(v), a);
      chk("R1 ack low", a, 0);
      chk("R4 pin after byte", pin, 0);
      chk("R3 m_data", m_data, v);
      chk("R6 m_valid", m_valid, 1);
      chk("R7 int_n", int_n, 0);
      tb_scl_low = 1'b0; wclk(10);
      chk("R8 stretch", scl_line, 0);
      tb_scl_low = 1'b1;
      host_read();
      chk("R6 pin after read", pin, 1);
      chk("R8 release", scl_oe, 0);
    end
    bus_stop();
    chk("R9 pin on stop", pin, 0); chk("R9 stop flag", sts_stop, 1);
    chk("R9 no stretch", scl_oe, 0);
    host_read();
    chk("R11 stop cleared", sts_stop, 0); chk("R11 pin", pin, 1);

    // not-acknowledge, interrupt disabled
    cfg_ack_en = 0; cfg_int_en = 0;
    bus_start();
    send_byte(8'hA5, a);
    chk("R2 nack", a, 1); chk("R4 pin", pin, 0); chk("R7 int masked", int_n, 1);
    chk("R3 m_data A5", m_data, 8'hA5);
    tb_scl_low = 1'b1; host_read();
    bus_stop(); host_read();
    cfg_int_en = 1;

    // master receiver, ack toggling
    cfg_master = 1; cfg_tx = 0;
    bus_start();
    for (int i = 0; i < 32; i++) begin
      logic [7:0] v;
      v = 8'((i * 53 + 7) & 255);
      cfg_ack_en = i[0];
      send_byte(v, a);
      chk(i[0] ? "R1 master ack" : "R2 master nack", a, !i[0]);
      chk("R3 master data", m_data, v);
      chk("R8 master no stretch", scl_oe, 0);
      chk("R4 master pin", pin, 0);
      host_read();
    end
    bus_stop();
    chk("R9 stop ignored in master", pin, 1);

    // slave transmitter
    cfg_master = 0; cfg_tx = 1; cfg_ack_en = 1;
    bus_start();
    for (int i = 0; i < 64; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + 5) & 255);
      chk("R5 s_ready idle", s_ready, 1);
      host_write(v);
      chk("R5 pin after write", pin, 1);
      for (int j = 7; j >= 0; j--) begin
        clk_bit(1'b1, got[j]);
        if (j == 7) chk("R5 s_ready mid byte", s_ready, 0);
      end
      clk_bit(i[0] ? 1'b1 : 1'b0, a);
      tb_sda_low = 1'b0;
      wclk(8);
      chk("R3 tx byte", got, v);
      chk("R3 ack seen", sts_ack_rx, i[0]);
      chk("R4 tx pin", pin, 0);
      chk("R8 tx stretch", scl_oe, 1);
      chk("R6 m_valid low in tx", m_valid, 0);
    end
    host_write(8'hFF);
    bus_stop();
    chk("R9 tx stop no pin", pin, 1);

    // bus errors in slave receiver
    cfg_tx = 0; cfg_ack_en = 1;
    bus_start();
    for (int j = 0; j < 3; j++) clk_bit(1'b0, a);
    tb_sda_low = 1'b0; wclk(HALF);
    tb_scl_low = 1'b0; wait_scl_high(); wclk(HALF);
    tb_sda_low = 1'b1; wclk(8);
    chk("R10 pin", pin, 0); chk("R10 ber", sts_ber, 1);
    chk("R10 scl free", scl_oe, 0); chk("R10 sda free", sda_oe, 0);
    chk("R7 int on ber", int_n, 0);
    tb_scl_low = 1'b1; wclk(HALF);
    host_read();
    chk("R11 ber cleared", sts_ber, 0); chk("R11 pin", pin, 1);
    send_byte(8'h3C, a);
    chk("R10 restart ack", a, 0); chk("R10 restart data", m_data, 8'h3C);
    host_read();
    for (int j = 0; j < 5; j++) clk_bit(1'b1, a);
    bus_stop();
    chk("R10 stop ber", sts_ber, 1); chk("R10 stop flag off", sts_stop, 0);
    chk("R10 pin", pin, 0);
    host_read();
    chk("R11 cleared", sts_ber, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule